// File: doc/BRIEF.md
# Banked Multichannel Sample Capture Buffer

The block records a stream of parallel samples, one per input channel on every beat, into a set of equal memory banks. At the start of each capture run a banking mode is chosen. Mode m makes the low 2^m channels active and joins the banks into chains, one chain per active channel, so that fewer channels each get deeper storage. Data on inactive channels is discarded.

A capture run begins with a start command on a small configuration stream. It ends either on a stop command or when the chains are full, whichever comes first. Full is shared: every active channel writes on the same beats, so the last bank of every chain fills on the same cycle, and writing then stops for all channels together. The stored samples then drain through a valid/ready output stream, one channel after another, each channel oldest first, with a flag on the final sample of each channel. The output holds its beat for as long as ready stays low. The input stream has no back-pressure: a beat presented while the block is not capturing is dropped. The configuration stream deasserts its ready during readout, so a command offered in that phase waits until readout finishes.

The default bank depth is kept small so the block is cheap to elaborate. The intended deployment sets `BANK_DEPTH` to 1024, which gives 8192 entries in mode 0. The single clock has a synchronous active-high reset.

Top module: `sbuf_capture`

## Requirements
- R1: After reset, `out_valid` is low and `cfg_ready` is high.
- R2: Configuration word fields: bit 0 is start, bit 1 is stop, bits [3:2] are the banking mode. A start accepted while idle latches the mode and clears the stored count. A word carrying only stop while idle has no effect.
- R3: In mode m each active channel stores up to (NCH·BANK_DEPTH)/2^m samples. Channel c fills banks c, c+2^m, c+2·2^m and so on, in order, and moves to the next bank after BANK_DEPTH entries.
- R4: Only channels 0 to 2^m−1 are stored and read out. After the last beat of channel 2^m−1, no further beat appears.
- R5: During capture a sample is stored only in a cycle with `in_valid` high. Gap cycles neither store nor advance the write position.
- R6: When the capacity is reached, capture ends for all channels and readout begins. Later input beats are dropped, and `cfg_ready` goes low.
- R7: A stop command ends capture, and a beat presented in the same cycle as the stop is still stored. A stop with nothing stored returns the block to idle with no output beat.
- R8: Readout visits channels in ascending order, each channel oldest first. `out_last` is high exactly on each channel's final sample.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R10: `cfg_ready` is low throughout readout. After the final handshake the block returns to idle with `cfg_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_data | input | NCH*SW | One sample per channel, channel c at bits [c*SW +: SW] |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Configuration word accepted; low during readout |
| cfg_data | input | CFG_W | Start (bit 0), stop (bit 1), banking mode (upper bits) |
| out_valid | output | 1 | Readout beat present |
| out_ready | input | 1 | Consumer accepts readout beat |
| out_data | output | SW | Stored sample |
| out_last | output | 1 | Final sample of the current channel |

## Verification
Two functions can meet in a single cycle. The first is the end of capture: a stop command can arrive on the same cycle as an input beat, or the beat that fills the chains can arrive while a stop is about to be sent. In the first case the bench drives a stop together with the final beat and expects that beat in the readout. In the second it fills the chains exactly and then checks that `cfg_ready` has already dropped, so no stop is needed. The second meeting is between output back-pressure and the channel change: at a channel boundary the next bank's read can be issued while the current beat is still stalled. Ready patterns that toggle across those boundaries are judged by checking every beat's value, its `out_last`, and that a stalled beat stays unchanged.

// File: rtl/sbuf_pkg.sv
`timescale 1ns/1ps
package sbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAP  = 2'd1,
    ST_READ = 2'd2
  } sbuf_state_e;

  localparam int CFG_START_BIT = 0;
  localparam int CFG_STOP_BIT  = 1;
  localparam int CFG_MODE_LSB  = 2;
endpackage

// File: rtl/sbuf_bank.sv
`timescale 1ns/1ps
module sbuf_bank #(
  parameter int DEPTH = 64,
  parameter int SW    = 16,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [SW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [SW-1:0] rdata
);
  logic [SW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read, holds when not enabled so a stalled beat stays put
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sbuf_ctrl.sv
`timescale 1ns/1ps
module sbuf_ctrl
  import sbuf_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int DEPTH  = 64,
  parameter int MODE_W = 2,
  parameter int CFG_W  = 4,
  parameter int CW     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_valid,
  input  logic [CFG_W-1:0]  cfg_data,
  output logic              cfg_ready,
  input  logic              in_valid,
  input  logic              rd_done,
  output sbuf_state_e       state_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [CW-1:0]     wcnt_o,
  output logic              cap_we_o
);
  localparam logic [CW-1:0] TOTAL = CW'(NCH * DEPTH);

  sbuf_state_e       state_q;
  logic [MODE_W-1:0] mode_q;
  logic [CW-1:0]     wcnt_q, cap, wcnt_inc;
  logic              cfg_fire, go, halt, hit_full;

  assign cfg_ready = (state_q != ST_READ);
  assign cfg_fire  = cfg_valid & cfg_ready;
  assign go        = cfg_fire & cfg_data[CFG_START_BIT];
  assign halt      = cfg_fire & cfg_data[CFG_STOP_BIT];
  assign cap       = TOTAL >> mode_q;
  assign cap_we_o  = (state_q == ST_CAP) & in_valid;
  assign wcnt_inc  = wcnt_q + CW'(cap_we_o);
  assign hit_full  = cap_we_o & (wcnt_inc == cap);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      wcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_CAP;
          wcnt_q  <= '0;
          mode_q  <= cfg_data[CFG_MODE_LSB +: MODE_W];
        end
        ST_CAP: begin
          wcnt_q <= wcnt_inc;
          if (halt | hit_full) state_q <= (wcnt_inc == '0) ? ST_IDLE : ST_READ;
        end
        ST_READ: if (rd_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;
  assign wcnt_o  = wcnt_q;

  // R3: stored count never passes the per-channel capacity of the latched mode
  p_wcnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    wcnt_q <= cap);
  // R5: a gap cycle leaves the write position alone
  p_gap_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CAP && !in_valid) |=> $stable(wcnt_q));
  // R2: the mode only changes while idle
  p_mode_latched_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(mode_q));
  // R6: the filling beat moves the block straight to readout
  p_full_ends_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CAP && in_valid && wcnt_q == cap - CW'(1)) |=>
      (state_q == ST_READ && wcnt_q == cap));
  // R6: nothing is written once readout has begun
  p_drop_after_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ) |=> $stable(wcnt_q));
endmodule

// File: rtl/sbuf_reader.sv
`timescale 1ns/1ps
module sbuf_reader #(
  parameter int NCH    = 8,
  parameter int MODE_W = 2,
  parameter int CW     = 10,
  parameter int AW     = 6,
  parameter int CHW    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CW-1:0]     count_i,
  input  logic              out_ready_i,
  output logic              rd_en_o,
  output logic [CHW-1:0]    rd_bank_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic [CHW-1:0]    sel_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              done_o
);
  localparam int CH1 = CHW + 1;

  logic [CHW-1:0] ch_q, sel_q;
  logic [CW-1:0]  idx_q, slot;
  logic           fin_q, ov_q, ol_q;
  logic [CH1-1:0] nact;
  logic           idx_last, ch_last, slot_free;

  assign nact      = CH1'(1) << mode_i;
  assign ch_last   = ({1'b0, ch_q} == nact - CH1'(1));
  assign idx_last  = (idx_q == count_i - CW'(1));
  assign slot      = idx_q >> AW;
  assign rd_bank_o = ch_q + CHW'(slot << mode_i);
  assign rd_addr_o = idx_q[AW-1:0];
  assign slot_free = !ov_q | out_ready_i;
  assign rd_en_o   = active_i & !fin_q & slot_free;
  assign done_o    = active_i & fin_q & slot_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_q <= '0; idx_q <= '0; fin_q <= 1'b0;
      ov_q <= 1'b0; ol_q <= 1'b0; sel_q <= '0;
    end else if (!active_i) begin
      ch_q <= '0; idx_q <= '0; fin_q <= 1'b0; ov_q <= 1'b0;
    end else if (rd_en_o) begin
      ov_q  <= 1'b1;
      ol_q  <= idx_last;
      sel_q <= rd_bank_o;
      if (idx_last) begin
        idx_q <= '0;
        if (ch_last) fin_q <= 1'b1;
        else         ch_q  <= ch_q + CHW'(1);
      end else begin
        idx_q <= idx_q + CW'(1);
      end
    end else if (out_ready_i) begin
      ov_q <= 1'b0;
    end
  end

  assign sel_o   = sel_q;
  assign valid_o = ov_q;
  assign last_o  = ol_q;

  // R10: no beat is offered outside the readout phase
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !active_i |-> !ov_q);
  // R8: the output flag follows the index position of the fetched beat
  p_last_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en_o && !idx_last) |=> !last_o);
endmodule

// File: rtl/sbuf_capture.sv
`timescale 1ns/1ps
module sbuf_capture
  import sbuf_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int BANK_DEPTH = 64,
  parameter int SW         = 16,
  localparam int CFG_W     = 2 + $clog2($clog2(NCH) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [NCH*SW-1:0] in_data,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [CFG_W-1:0]  cfg_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SW-1:0]     out_data,
  output logic              out_last
);
  localparam int MODE_W = CFG_W - 2;
  localparam int AW     = $clog2(BANK_DEPTH);
  localparam int CHW    = $clog2(NCH);
  localparam int CW     = $clog2(NCH * BANK_DEPTH) + 1;

  sbuf_state_e       state;
  logic [MODE_W-1:0] mode;
  logic [CW-1:0]     wcnt, wslot;
  logic              cap_we, rd_en, rd_done;
  logic [CHW-1:0]    rd_bank, sel;
  logic [AW-1:0]     rd_addr;
  logic [SW-1:0]     bank_q [NCH];

  sbuf_ctrl #(
    .NCH(NCH), .DEPTH(BANK_DEPTH), .MODE_W(MODE_W), .CFG_W(CFG_W), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
    .cfg_ready(cfg_ready), .in_valid(in_valid), .rd_done(rd_done),
    .state_o(state), .mode_o(mode), .wcnt_o(wcnt), .cap_we_o(cap_we)
  );

  assign wslot = wcnt >> AW;

  for (genvar b = 0; b < NCH; b++) begin : g_bank
    logic [CHW-1:0] owner;
    logic [CW-1:0]  slot_b;
    logic           wr, rd;
    // bank b belongs to channel (b mod 2^m) as chain position (b / 2^m)
    assign owner  = CHW'(b) & CHW'((32'd1 << mode) - 32'd1);
    assign slot_b = CW'(b) >> mode;
    assign wr     = cap_we & (slot_b == wslot);
    assign rd     = rd_en & (rd_bank == CHW'(b));

    sbuf_bank #(.DEPTH(BANK_DEPTH), .SW(SW), .AW(AW)) u_bank (
      .clk(clk), .we(wr), .waddr(wcnt[AW-1:0]),
      .wdata(in_data[owner*SW +: SW]),
      .re(rd), .raddr(rd_addr), .rdata(bank_q[b])
    );
  end

  sbuf_reader #(
    .NCH(NCH), .MODE_W(MODE_W), .CW(CW), .AW(AW), .CHW(CHW)
  ) u_reader (
    .clk(clk), .rst(rst), .active_i(state == ST_READ), .mode_i(mode),
    .count_i(wcnt), .out_ready_i(out_ready), .rd_en_o(rd_en),
    .rd_bank_o(rd_bank), .rd_addr_o(rd_addr), .sel_o(sel),
    .valid_o(out_valid), .last_o(out_last), .done_o(rd_done)
  );

  assign out_data = bank_q[sel];

  // R9: a stalled beat is held unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));
  // R10: configuration is refused for the whole readout phase
  p_cfg_block_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !cfg_ready);
endmodule

// File: tb/sbuf_capture_tb_top.sv
`timescale 1ns/1ps
module sbuf_capture_tb_top;
  localparam int NCH   = 8;
  localparam int DEPTH = 64;
  localparam int SW    = 16;
  localparam int CFG_W = 4;
  localparam int TOTAL = NCH * DEPTH;
  localparam int NV    = 8;

  // vector table: mode, beats, gap period (0 = none), ready-low period (0 = none)
  localparam int V_MODE[NV] = '{0, 1, 2, 3, 0, 3, 2, 1};
  localparam int V_N   [NV] = '{5, 100, 128, 64, 600, 90, 65, 0};
  localparam int V_GAP [NV] = '{0, 3, 0, 2, 0, 0, 5, 0};
  localparam int V_RDY [NV] = '{0, 0, 2, 3, 0, 4, 0, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [NCH*SW-1:0] in_data = '0;
  logic cfg_valid = 1'b0;
  logic [CFG_W-1:0] cfg_data = '0;
  logic cfg_ready, out_valid, out_last;
  logic out_ready = 1'b0;
  logic [SW-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sbuf_capture #(.NCH(NCH), .BANK_DEPTH(DEPTH), .SW(SW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] tag(input int c, input int k);
    return SW'((c << 12) | (k & 12'hFFF));
  endfunction

  function automatic logic [NCH*SW-1:0] beat(input int k);
    logic [NCH*SW-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*SW +: SW] = tag(c, k);
    return v;
  endfunction

  task automatic run_case(input int m, input int n, input int gap,
                          input int rdy_per, input bit stop_last);
    int cap, stored, nact, total, cnt, tmo;
    bit rdy, hold;
    logic [SW-1:0] pdata;
    logic plast;
    string lbl;
    cap    = TOTAL >> m;
    stored = (n < cap) ? n : cap;
    nact   = 1 << m;
    total  = nact * stored;
    // start with mode in bits [3:2], start bit 0
    cfg_valid = 1'b1; cfg_data = CFG_W'((m << 2) | 1);
    @(negedge clk);
    cfg_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1; in_data = beat(k);
      if (stop_last && k == n - 1 && cfg_ready) begin
        cfg_valid = 1'b1; cfg_data = 4'b0010;
      end
      @(negedge clk);
      in_valid = 1'b0; cfg_valid = 1'b0;
      if (gap > 0 && (k % gap) == gap - 1) @(negedge clk);
    end
    if (n >= cap) check(cfg_ready == 1'b0, "R6 capture ended at capacity", cfg_ready, 0);
    if (!stop_last && cfg_ready) begin
      cfg_valid = 1'b1; cfg_data = 4'b0010;
      @(negedge clk);
      cfg_valid = 1'b0;
    end
    if (total > 0) check(cfg_ready == 1'b0, "R10 cfg_ready low in readout", cfg_ready, 0);
    lbl = (gap > 0) ? "R5 R8 data" : ((n > cap) ? "R6 R8 data" : "R8 data");
    cnt = 0; tmo = 0; hold = 1'b0; pdata = '0; plast = 1'b0;
    while (cnt < total && tmo < 4 * total + 100) begin
      rdy = (rdy_per == 0) || ((tmo % rdy_per) != 0);
      out_ready = rdy;
      if (hold)
        check(out_valid && out_data == pdata && out_last == plast,
              "R9 stalled beat held", int'(out_data), int'(pdata));
      if (out_valid && rdy) begin
        check(out_data == tag(cnt / stored, cnt % stored), lbl,
              int'(out_data), int'(tag(cnt / stored, cnt % stored)));
        check(out_last == ((cnt % stored) == stored - 1), "R8 last flag",
              out_last, int'((cnt % stored) == stored - 1));
        cnt++;
      end
      hold = out_valid && !rdy; pdata = out_data; plast = out_last;
      @(negedge clk);
      tmo++;
    end
    out_ready = 1'b0;
    check(cnt == total, stop_last ? "R7 beat with stop kept" : "R3 stored count", cnt, total);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, (n == 0) ? "R7 empty stop no output" : "R4 no extra beats",
          out_valid, 0);
    check(cfg_ready == 1'b1, "R10 idle after readout", cfg_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(cfg_ready == 1'b1, "R1 cfg_ready after reset", cfg_ready, 1);

    // R3 R4 R5 R6 R8 R9: table of modes, lengths, gaps and back-pressure
    for (int v = 0; v < NV; v++)
      run_case(V_MODE[v], V_N[v], V_GAP[v], V_RDY[v], 1'b0);

    // R7: stop in the same cycle as the last beat
    run_case(3, 5, 0, 0, 1'b1);

    // R2: stop alone while idle is ignored; beats while idle dropped
    cfg_valid = 1'b1; cfg_data = 4'b0010; in_valid = 1'b1; in_data = beat(77);
    @(negedge clk);
    cfg_valid = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && cfg_ready == 1'b1, "R2 idle stop ignored",
          out_valid, 0);
    // R2: a fresh start after a full run clears the count and takes the new mode
    run_case(0, 512, 0, 0, 1'b0);
    run_case(1, 3, 2, 3, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule